// File: doc/BRIEF.md
# Shared-Memory Multicycle Datapath

This block is the 32-bit data path of a processor that finishes each instruction over several clock cycles and therefore gets by with a single memory for both instructions and data and a single ALU. That one ALU is reused in turn to advance the program counter by four, to form branch targets and to produce data results. An external sequencer drives the select and write-enable inputs on every cycle and reads back the instruction register and the ALU zero flag to choose its next step. The memory sits outside the block and is reached through a plain address, write-data, read-data and strobe port.

Inside are the program counter, the instruction register, a memory data register, two operand holding registers, a result register, a 32-entry register file with two read ports and one write port, an immediate extender and the select multiplexers. The holding registers capture on every clock edge. The program counter and the instruction register change only when their enables allow it.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low, the PC is RESET_PC (default 0) and the instruction register, the operand and result registers, the memory data register and every register-file entry are zero.
- R2: mem_addr is the PC when ctl_addr_sel=0 and the result register when ctl_addr_sel=1. mem_wdata is the B holding register. mem_rd and mem_wr follow ctl_mem_rd and ctl_mem_wr in the same cycle.
- R3: The instruction register takes mem_rdata at a clock edge only when ctl_ir_we=1. Otherwise it keeps its value.
- R4: ALU operand A is the PC when ctl_opa_sel=0 and the A holding register when ctl_opa_sel=1. For operand B, ctl_opb_sel code 0 selects the B register, 1 the constant 4, 2 the extended immediate, and 3 the extended immediate shifted left by two.
- R5: The immediate is IR[15:0]. It is zero-extended when ctl_ext_zero=1 and sign-extended when ctl_ext_zero=0.
- R6: ctl_alu_op codes: 0 add, 1 subtract (A minus B), 2 and, 3 or, 4 xor, 5 nor, 6 signed less-than, 7 unsigned less-than. The two compares give 1 or 0.
- R7: The PC loads at a clock edge when ctl_pc_we=1, or when ctl_pc_we_cond=1 and the ALU result in that cycle is zero. Otherwise it holds.
- R8: ctl_pc_src codes: 0 the ALU result of the current cycle, 1 the result register, 2 the jump target {PC[31:28], IR[25:0], 2'b00}, 3 the ALU result again.
- R9: The register-file write address is IR[20:16] when ctl_dst_sel=0 and IR[15:11] when ctl_dst_sel=1. The write data is the result register when ctl_wb_sel=0 and the memory data register when ctl_wb_sel=1. A write with ctl_reg_we=1 can be read in the following cycle.
- R10: Register 0 always reads as zero. Writes to it have no effect.
- R11: On every clock edge the A register takes register IR[25:21], the B register takes register IR[20:16], the memory data register takes mem_rdata, and the result register takes the ALU result.
- R12: alu_zero is high in the same cycle whenever the ALU result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_pc_we | input | 1 | Unconditional PC write |
| ctl_pc_we_cond | input | 1 | PC write when the ALU result is zero |
| ctl_pc_src | input | 2 | PC source select |
| ctl_addr_sel | input | 1 | Memory address select: PC or result register |
| ctl_mem_rd | input | 1 | Memory read request |
| ctl_mem_wr | input | 1 | Memory write request |
| ctl_ir_we | input | 1 | Instruction register load |
| ctl_reg_we | input | 1 | Register-file write enable |
| ctl_dst_sel | input | 1 | Destination field select |
| ctl_wb_sel | input | 1 | Write-back data select |
| ctl_opa_sel | input | 1 | ALU operand A select |
| ctl_opb_sel | input | 2 | ALU operand B select |
| ctl_ext_zero | input | 1 | Zero-extend the immediate instead of sign-extending it |
| ctl_alu_op | input | 3 | ALU operation |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| ir_q | output | 32 | Instruction register, for the sequencer |
| pc_q | output | 32 | Program counter |
| alu_zero | output | 1 | ALU result is zero |

## Verification
The assertions assume that the sequencer never raises the read and write strobes together. The register-file visibility check also assumes that the read address in the cycle after a write comes from the instruction register as it then stands. The bench acts as a well-behaved sequencer: every strobe cycle it drives carries exactly one of the two strobes, and it holds all control inputs low during reset. Each instruction is stepped through fetch, decode, execute and, where needed, memory and write-back cycles, and register contents are observed through the B register on mem_wdata one idle cycle after write-back.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;

  localparam int XLEN      = 32;
  localparam int REG_AW    = 5;
  localparam int IMM_W     = 16;
  localparam int JIDX_W    = 26;
  localparam int RS_LSB    = 21;
  localparam int RT_LSB    = 16;
  localparam int RD_LSB    = 11;
  localparam int PC_KEEP_W = XLEN - JIDX_W - 2;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_NOR  = 3'd5,
    ALU_SLT  = 3'd6,
    ALU_SLTU = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG    = 2'd0,
    OPB_FOUR   = 2'd1,
    OPB_IMM    = 2'd2,
    OPB_IMM_X4 = 2'd3
  } opb_sel_e;

  typedef enum logic [1:0] {
    PCS_ALU     = 2'd0,
    PCS_ALUOUT  = 2'd1,
    PCS_JUMP    = 2'd2,
    PCS_ALU_ALT = 2'd3
  } pc_src_e;

  function automatic logic [XLEN-1:0] alu_calc(alu_op_e op, logic [XLEN-1:0] a,
                                               logic [XLEN-1:0] b);
    logic [XLEN-1:0] y;
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
      default:  y = '0;
    endcase
    return y;
  endfunction

  function automatic logic [XLEN-1:0] imm_widen(logic [IMM_W-1:0] imm, logic zero_mode);
    logic fill;
    fill = zero_mode ? 1'b0 : imm[IMM_W-1];
    return {{(XLEN-IMM_W){fill}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(logic [XLEN-1:0] pc,
                                                logic [JIDX_W-1:0] idx);
    return {pc[XLEN-1 -: PC_KEEP_W], idx, 2'b00};
  endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W     = 32,
  parameter int AW    = 5,
  parameter int NREGS = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);

  logic [W-1:0] regs [1:NREGS-1];
  logic         past_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < NREGS; i++) regs[i] <= '0;
    end else begin
      for (int i = 1; i < NREGS; i++) begin
        if (we && (waddr == AW'(i))) regs[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 1; i < NREGS; i++) begin
      if (raddr_a == AW'(i)) rdata_a = regs[i];
      if (raddr_b == AW'(i)) rdata_b = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  AST_RF_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(we) && ($past(waddr) != '0) && (raddr_a == $past(waddr)))
      |-> (rdata_a == $past(wdata))); // R9

  AST_RF_ZERO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(we) && ($past(waddr) == '0) && (raddr_b == '0))
      |-> (rdata_b == '0)); // R10

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_dp_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  assign y    = alu_calc(alu_op_e'(op), a, b);
  assign zero = (y == '0);

  always_comb begin
    if (((op == ALU_SLT) || (op == ALU_SLTU)) && !$isunknown(y)) begin
      AST_CMP_ONE_BIT: assert (y[XLEN-1:1] == '0); // R6
    end
  end

endmodule

// File: rtl/mc_imm_ext.sv
module mc_imm_ext
  import mc_dp_pkg::*;
(
  input  logic [IMM_W-1:0] imm,
  input  logic             zero_mode,
  output logic [XLEN-1:0]  ext,
  output logic [XLEN-1:0]  ext_x4
);

  assign ext    = imm_widen(imm, zero_mode);
  assign ext_x4 = {ext[XLEN-3:0], 2'b00};

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_dp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_pc_we,
  input  logic        ctl_pc_we_cond,
  input  logic [1:0]  ctl_pc_src,
  input  logic        ctl_addr_sel,
  input  logic        ctl_mem_rd,
  input  logic        ctl_mem_wr,
  input  logic        ctl_ir_we,
  input  logic        ctl_reg_we,
  input  logic        ctl_dst_sel,
  input  logic        ctl_wb_sel,
  input  logic        ctl_opa_sel,
  input  logic [1:0]  ctl_opb_sel,
  input  logic        ctl_ext_zero,
  input  logic [2:0]  ctl_alu_op,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] ir_q,
  output logic [31:0] pc_q,
  output logic        alu_zero
);

  localparam int NREGS = 1 << REG_AW;

  logic [XLEN-1:0]   a_q, b_q, mdr_q, aluout_q;
  logic [XLEN-1:0]   rf_rd_a, rf_rd_b;
  logic [XLEN-1:0]   imm_ext, imm_ext_x4;
  logic [XLEN-1:0]   opa, opb, alu_y;
  logic [XLEN-1:0]   pc_next, wb_data;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, wb_addr;
  logic              pc_load;

  assign rs_idx = ir_q[RS_LSB +: REG_AW];
  assign rt_idx = ir_q[RT_LSB +: REG_AW];
  assign rd_idx = ir_q[RD_LSB +: REG_AW];

  mc_regfile #(.W(XLEN), .AW(REG_AW), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rf_rd_a),
    .rdata_b (rf_rd_b),
    .we      (ctl_reg_we),
    .waddr   (wb_addr),
    .wdata   (wb_data)
  );

  mc_imm_ext u_ext (
    .imm       (ir_q[IMM_W-1:0]),
    .zero_mode (ctl_ext_zero),
    .ext       (imm_ext),
    .ext_x4    (imm_ext_x4)
  );

  assign opa = ctl_opa_sel ? a_q : pc_q;

  always_comb begin
    unique case (opb_sel_e'(ctl_opb_sel))
      OPB_REG:    opb = b_q;
      OPB_FOUR:   opb = XLEN'(4);
      OPB_IMM:    opb = imm_ext;
      OPB_IMM_X4: opb = imm_ext_x4;
      default:    opb = b_q;
    endcase
  end

  mc_alu u_alu (
    .op   (ctl_alu_op),
    .a    (opa),
    .b    (opb),
    .y    (alu_y),
    .zero (alu_zero)
  );

  always_comb begin
    unique case (pc_src_e'(ctl_pc_src))
      PCS_ALUOUT: pc_next = aluout_q;
      PCS_JUMP:   pc_next = jump_dest(pc_q, ir_q[JIDX_W-1:0]);
      default:    pc_next = alu_y;
    endcase
  end

  assign pc_load = ctl_pc_we | (ctl_pc_we_cond & alu_zero);

  assign wb_addr = ctl_dst_sel ? rd_idx : rt_idx;
  assign wb_data = ctl_wb_sel ? mdr_q : aluout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
      ir_q <= '0;
    end else begin
      if (pc_load)   pc_q <= pc_next;
      if (ctl_ir_we) ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= '0;
      b_q      <= '0;
      mdr_q    <= '0;
      aluout_q <= '0;
    end else begin
      a_q      <= rf_rd_a;
      b_q      <= rf_rd_b;
      mdr_q    <= mem_rdata;
      aluout_q <= alu_y;
    end
  end

  assign mem_addr  = ctl_addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = ctl_mem_rd;
  assign mem_wr    = ctl_mem_wr;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_mem_rd && ctl_mem_wr)); // R2

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ir_we |=> $stable(ir_q)); // R3

  AST_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ir_we |=> (ir_q == $past(mem_rdata))); // R3

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_pc_we && !(ctl_pc_we_cond && alu_zero)) |=> $stable(pc_q)); // R7

  AST_PC_COND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_we_cond && alu_zero) |=> (pc_q == $past(pc_next))); // R7

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_pc_we && (ctl_pc_src == 2'd2)) |=>
      ((pc_q[31:28] == $past(pc_q[31:28])) && (pc_q[27:2] == $past(ir_q[25:0]))
       && (pc_q[1:0] == 2'b00))); // R8

  AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_addr_sel && $past(alu_zero)) |-> (mem_addr == '0)); // R11

endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       pc_we;
    logic       pc_cond;
    logic [1:0] pc_src;
    logic       addr_sel;
    logic       mrd;
    logic       mwr;
    logic       ir_we;
    logic       reg_we;
    logic       dst;
    logic       wb;
    logic       opa;
    logic [1:0] opb;
    logic       ext_zero;
    logic [2:0] op;
  } ctl_t;

  ctl_t        ctl = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, ir_q, pc_q;
  logic        mem_rd, mem_wr, alu_zero;
  logic [31:0] mem [0:255];

  mc_datapath u_mc_datapath (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_pc_we      (ctl.pc_we),
    .ctl_pc_we_cond (ctl.pc_cond),
    .ctl_pc_src     (ctl.pc_src),
    .ctl_addr_sel   (ctl.addr_sel),
    .ctl_mem_rd     (ctl.mrd),
    .ctl_mem_wr     (ctl.mwr),
    .ctl_ir_we      (ctl.ir_we),
    .ctl_reg_we     (ctl.reg_we),
    .ctl_dst_sel    (ctl.dst),
    .ctl_wb_sel     (ctl.wb),
    .ctl_opa_sel    (ctl.opa),
    .ctl_opb_sel    (ctl.opb),
    .ctl_ext_zero   (ctl.ext_zero),
    .ctl_alu_op     (ctl.op),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_rdata      (mem_rdata),
    .mem_rd         (mem_rd),
    .mem_wr         (mem_wr),
    .ir_q           (ir_q),
    .pc_q           (pc_q),
    .alu_zero       (alu_zero)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

  // Sequencer opcodes used by this bench only
  localparam logic [5:0] K_R = 6'd0, K_J = 6'd2, K_BEQ = 6'd4, K_ADDI = 6'd8,
                         K_ORI = 6'd13, K_LW = 6'd35, K_SW = 6'd43;

  // Columns: word address, opcode, rs, rt, low 16 bits, expected value
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV][6] = '{
    '{32'd0,  32'd13, 32'd0, 32'd1, 32'h8001, 32'h0000_8001},
    '{32'd1,  32'd8,  32'd0, 32'd2, 32'hFFFB, 32'hFFFF_FFFB},
    '{32'd2,  32'd0,  32'd1, 32'd2, 32'h1000, 32'h0000_7FFC},
    '{32'd3,  32'd0,  32'd2, 32'd1, 32'h0801, 32'hFFFF_FFFB},
    '{32'd4,  32'd8,  32'd1, 32'd0, 32'h0005, 32'h0000_0000},
    '{32'd5,  32'd13, 32'd0, 32'd3, 32'h0200, 32'h0000_0200},
    '{32'd6,  32'd35, 32'd3, 32'd4, 32'h0004, 32'hCAFE_F00D},
    '{32'd7,  32'd43, 32'd3, 32'd4, 32'hFFFC, 32'hCAFE_F00D},
    '{32'd8,  32'd4,  32'd1, 32'd2, 32'h0005, 32'd36},
    '{32'd9,  32'd4,  32'd4, 32'd4, 32'h0002, 32'd48},
    '{32'd12, 32'd2,  32'd0, 32'd0, 32'h000F, 32'd60},
    '{32'd15, 32'd0,  32'd1, 32'd4, 32'h2002, 32'hCAFE_F009},
    '{32'd16, 32'd0,  32'd0, 32'd5, 32'h2803, 32'h0000_0000},
    '{32'd17, 32'd0,  32'd1, 32'd2, 32'h1006, 32'h0000_0001},
    '{32'd18, 32'd0,  32'd1, 32'd3, 32'h1804, 32'hFFFF_FDFB},
    '{32'd19, 32'd0,  32'd0, 32'd3, 32'h1805, 32'h0000_0204},
    '{32'd20, 32'd0,  32'd4, 32'd3, 32'h1807, 32'h0000_0000},
    '{32'd21, 32'd0,  32'd0, 32'd0, 32'h0000, 32'h0000_0000}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [31:0] enc(logic [31:0] op, logic [31:0] rs, logic [31:0] rt,
                                      logic [31:0] low);
    return {op[5:0], rs[4:0], rt[4:0], low[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(ctl_t c);
    ctl = c;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    ctl_t c;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[10]  = enc(32'd13, 32'd0, 32'd5, 32'h0BAD);
    mem[11]  = enc(32'd13, 32'd0, 32'd5, 32'h0BAD);
    mem[13]  = enc(32'd13, 32'd0, 32'd5, 32'h0BAD);
    mem[14]  = enc(32'd13, 32'd0, 32'd5, 32'h0BAD);
    mem[129] = 32'hCAFE_F00D;
    for (int v = 0; v < NV - 1; v++)
      mem[VEC[v][0][7:0]] = enc(VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
    mem[21] = 32'h1234_5678;

    repeat (2) @(negedge clk);
    chk("R1 reset pc", pc_q, 32'h0);
    chk("R1 reset ir", ir_q, 32'h0);
    chk("R1 reset B register on mem_wdata", mem_wdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV - 1; v++) begin
      logic [31:0] at, op, exp, instr;
      at    = VEC[v][0];
      op    = VEC[v][1];
      exp   = VEC[v][5];
      instr = enc(VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      chk("R8 control flow pc before fetch", pc_q, at * 4);

      // fetch: PC + 4 through operand A = PC, operand B = 4
      c = '0; c.mrd = 1'b1; c.ir_we = 1'b1; c.opb = 2'd1; c.pc_we = 1'b1;
      ctl = c; #1;
      chk("R2 fetch address from pc", mem_addr, at * 4);
      chk("R2 read strobe", {31'b0, mem_rd}, 32'h1);
      @(negedge clk);
      chk("R3 ir loaded on fetch", ir_q, instr);
      chk("R4 R7 pc advanced by four", pc_q, at * 4 + 4);

      // decode: branch target into result register
      c = '0; c.opb = 2'd3; tick(c);

      case (op[5:0])
        K_R: begin
          c = '0; c.opa = 1'b1; c.op = VEC[v][4][2:0]; tick(c);
          c = '0; c.reg_we = 1'b1; c.dst = 1'b1; tick(c);
          tick('0);
          chk("R6 R9 register op result via B", mem_wdata, exp);
        end
        K_ORI, K_ADDI: begin
          c = '0; c.opa = 1'b1; c.opb = 2'd2;
          c.ext_zero = (op[5:0] == K_ORI); c.op = (op[5:0] == K_ORI) ? 3'd3 : 3'd0;
          tick(c);
          c = '0; c.reg_we = 1'b1; tick(c);
          tick('0);
          if (VEC[v][3] == 32'd0) chk("R10 register 0 write ignored", mem_wdata, exp);
          else chk("R5 R9 immediate result via B", mem_wdata, exp);
        end
        K_LW: begin
          c = '0; c.opa = 1'b1; c.opb = 2'd2; tick(c);
          c = '0; c.addr_sel = 1'b1; c.mrd = 1'b1;
          ctl = c; #1;
          chk("R2 data address from result register", mem_addr, 32'h204);
          @(negedge clk);
          c = '0; c.reg_we = 1'b1; c.wb = 1'b1; tick(c);
          tick('0);
          chk("R11 R9 loaded word through data register", mem_wdata, exp);
        end
        K_SW: begin
          c = '0; c.opa = 1'b1; c.opb = 2'd2; tick(c);
          c = '0; c.addr_sel = 1'b1; c.mwr = 1'b1;
          ctl = c; #1;
          chk("R2 store address", mem_addr, 32'h1FC);
          chk("R2 store data from B", mem_wdata, exp);
          chk("R2 write strobe", {31'b0, mem_wr}, 32'h1);
          @(negedge clk);
          tick('0);
          chk("R2 stored word", mem[127], exp);
        end
        K_BEQ: begin
          c = '0; c.opa = 1'b1; c.op = 3'd1; c.pc_cond = 1'b1; c.pc_src = 2'd1;
          ctl = c; #1;
          chk("R12 zero flag on compare", {31'b0, alu_zero},
              {31'b0, (exp != at * 4 + 4)});
          @(negedge clk);
          chk("R7 conditional pc update", pc_q, exp);
        end
        K_J: begin
          c = '0; c.pc_we = 1'b1; c.pc_src = 2'd2; tick(c);
          chk("R8 jump target", pc_q, exp);
        end
        default: chk("bench opcode", op, 32'h0);
      endcase
    end

    // directed: IR holds with read enabled but no load; conditional write with nonzero result
    chk("R8 pc at end of program", pc_q, 32'd84);
    c = '0; c.mrd = 1'b1; c.opa = 1'b1; c.op = 3'd1; c.pc_cond = 1'b1; c.pc_src = 2'd1;
    tick(c);
    chk("R3 ir holds without load", ir_q, enc(32'd0, 32'd4, 32'd3, 32'h1807));
    chk("R7 pc holds on nonzero compare", pc_q, 32'd84);

    // directed: PC source code 3 uses the ALU result
    c = '0; c.pc_we = 1'b1; c.pc_src = 2'd3; c.opb = 2'd1; tick(c);
    chk("R8 source code 3 alu result", pc_q, 32'd88);

    // directed: reset in mid-run clears PC, IR and register file
    rst_n = 1'b0;
    ctl = '0;
    #1;
    chk("R1 async reset pc", pc_q, 32'h0);
    chk("R1 async reset ir", ir_q, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    c = '0; c.mrd = 1'b1; c.ir_we = 1'b1; c.opb = 2'd1; c.pc_we = 1'b1; tick(c);
    tick('0);
    chk("R1 R11 register file cleared by reset", mem_wdata, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule